// File: doc/BRIEF.md
# Front-end derandomizer with contiguous frame packer

This block sits at the output of a detector front-end. On every bunch crossing it may receive one event fragment: a crossing number, a hit mask over the channels and one 5-bit word per channel. It turns each accepted fragment into a serial event. The event starts with a 24-bit header followed by the selected channel words. The event goes into a bit-granular derandomizer buffer. Two synchronous command strobes travel with each crossing. One vetoes the crossing, so its fragment never reaches the buffer. The other requests a non-zero-suppressed readout, in which every channel is sent whatever the mask says.

On every clock the block emits one 80-bit link payload and a 4-bit frame code. Events are laid into the payloads back to back, starting at the top bit. An event that does not fit in what is left of a payload continues at the top of the next one, so no padding appears between events. A code tells the receiver whether a payload is full, is the last partial drain of the buffer, or is idle.

If a fragment would not fit in the free buffer space, it is dropped. A sticky flag then rises and the crossing number of the lost fragment is kept. The buffer fill, counted in bits, is available as an output.

Top module: `fe_derand_packer`

## Requirements
- R1: Every event begins with a 24-bit header. In stream order it carries the 12-bit crossing number (MSB first), then an 8-bit count of the channel words that follow, then a 4-bit info field. The info field is 4'b1000 for a non-zero-suppressed event and 4'b0000 otherwise.
- R2: Without the non-zero-suppressed request, only channels whose mask bit is 1 are sent. They go lowest index first, each as its 5 data bits MSB first, and an event with no hits is a header alone.
- R3: With the non-zero-suppressed request, all channel words are sent whatever the mask, and the count equals the channel count.
- R4: Payload bits are filled from bit 79 downward. Events follow one another with no gap and in arrival order, and an event that runs past bit 0 continues at bit 79 of the next payload.
- R5: A fragment presented with the veto strobe is discarded. It adds nothing to the buffer or the output stream and does not raise the overflow flag.
- R6: Frame kind is decided from the buffer fill held before the clock edge. A fill of 80 bits or more gives a full payload with code 4'h6. A fill of 1 to 79 bits gives all buffered bits, zeros below them, and code 4'h9. An empty buffer gives code 4'h0 and an all-zero payload.
- R7: A fragment accepted at one edge is buffered at that edge, and the reported fill includes it. Its bits appear in payloads from the next edge on.
- R8: A fragment longer than the buffer space free before the edge (capacity minus fill) is dropped whole. The overflow flag then goes high and stays high until reset, and the lost crossing number is captured; a later drop overwrites it.
- R9: Synchronous reset empties the buffer and clears the flag, the captured crossing number and the payload, and the frame code becomes 4'h0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | crossing clock |
| rst | input | 1 | synchronous reset, active high |
| in_valid | input | 1 | a fragment is present this crossing |
| in_bxid | input | 12 | crossing number of the fragment |
| in_hit_mask | input | NCH | one bit per channel, 1 = hit |
| in_ch_data | input | NCH*5 | channel words, channel k at bits [5k+4:5k] |
| cmd_veto | input | 1 | veto command for this crossing |
| cmd_nzs | input | 1 | non-zero-suppressed request for this crossing |
| frame_hdr | output | 4 | frame code: 0 idle, 9 partial drain, 6 full |
| frame_data | output | 80 | link payload |
| buf_occ | output | $clog2(BUF_BITS+1) | buffered bits |
| ovf_flag | output | 1 | sticky overflow |
| ovf_bxid | output | 12 | crossing number of the last dropped fragment |

## Verification
The frame code and payload registered at an edge depend only on the buffer contents before that edge. The fill, the overflow flag and the captured crossing number include the fragment sampled at that same edge. An event therefore shows up in a payload one edge after it is presented. The bench drives each crossing on the falling edge and steps a queue-of-bits model for that crossing. It then samples all outputs one nanosecond after the next rising edge and compares them on every cycle, so each result is checked in the cycle it is due. Phases cover empty headers, sparse and dense masks, straddling, the full-readout request, the veto, and a sustained burst that forces overflow.

// File: rtl/fe_pack_pkg.sv
package fe_pack_pkg;
    localparam int FRAME_W  = 80;
    localparam int EVHDR_W  = 24;
    localparam int WORD_W   = 5;
    localparam int BXID_W   = 12;
    localparam int FCODE_W  = 4;

    localparam logic [FCODE_W-1:0] CODE_IDLE = 4'h0;
    localparam logic [FCODE_W-1:0] CODE_TAIL = 4'h9;
    localparam logic [FCODE_W-1:0] CODE_FULL = 4'h6;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_TAIL = 2'd1,
        FR_FULL = 2'd2
    } frame_kind_e;
endpackage

// File: rtl/fe_event_builder.sv
module fe_event_builder
    import fe_pack_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int EV_MAX = EVHDR_W + WORD_W * NCH,
    parameter int LEN_W  = $clog2(EV_MAX + 1)
) (
    input  logic [BXID_W-1:0]     bxid,
    input  logic [NCH-1:0]        hit_mask,
    input  logic [NCH*WORD_W-1:0] ch_data,
    input  logic                  nzs,
    output logic [EV_MAX-1:0]     ev_bits,
    output logic [LEN_W-1:0]      ev_len
);
    logic [EVHDR_W-1:0] hdr;
    logic [7:0]         cnt;
    logic [3:0]         info;
    int                 pos;

    always_comb begin
        cnt = '0;
        for (int c = 0; c < NCH; c++) begin
            if (nzs || hit_mask[c]) cnt = cnt + 8'd1;
        end
        info = nzs ? 4'b1000 : 4'b0000;
        hdr  = {bxid, cnt, info};
        ev_bits = '0;
        for (int i = 0; i < EVHDR_W; i++) ev_bits[i] = hdr[EVHDR_W-1-i];
        pos = EVHDR_W;
        for (int c = 0; c < NCH; c++) begin
            if (nzs || hit_mask[c]) begin
                for (int b = 0; b < WORD_W; b++)
                    ev_bits[pos+b] = ch_data[c*WORD_W + WORD_W-1-b];
                pos = pos + WORD_W;
            end
        end
        ev_len = LEN_W'(EVHDR_W) + LEN_W'(cnt) * LEN_W'(WORD_W);
    end
endmodule

// File: rtl/fe_bit_fifo.sv
module fe_bit_fifo
    import fe_pack_pkg::*;
#(
    parameter int BUF_BITS = 256,
    parameter int EV_MAX   = 104,
    parameter int LEN_W    = $clog2(EV_MAX + 1),
    parameter int OCC_W    = $clog2(BUF_BITS + 1),
    parameter int TAKE_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [EV_MAX-1:0]  wr_bits,
    input  logic [LEN_W-1:0]   wr_len,
    input  logic [TAKE_W-1:0]  rd_take,
    output logic [OCC_W-1:0]   occ,
    output logic [FRAME_W-1:0] frame_q
);
    localparam int AW = $clog2(BUF_BITS);

    logic [BUF_BITS-1:0] mem, mem_n;
    logic [AW-1:0]       wr_ptr, rd_ptr;
    logic [FRAME_W-1:0]  rd_word;
    logic [OCC_W-1:0]    occ_n;

    always_comb begin
        mem_n = mem;
        for (int i = 0; i < EV_MAX; i++) begin
            if (wr_en && (LEN_W'(i) < wr_len))
                mem_n[wr_ptr + AW'(i)] = wr_bits[i];
        end
        for (int j = 0; j < FRAME_W; j++) begin
            rd_word[FRAME_W-1-j] = (TAKE_W'(j) < rd_take) ? mem[rd_ptr + AW'(j)] : 1'b0;
        end
        occ_n = occ - OCC_W'(rd_take) + (wr_en ? OCC_W'(wr_len) : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem     <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            occ     <= '0;
            frame_q <= '0;
        end else begin
            mem     <= mem_n;
            wr_ptr  <= wr_en ? wr_ptr + AW'(wr_len) : wr_ptr;
            rd_ptr  <= rd_ptr + AW'(rd_take);
            occ     <= occ_n;
            frame_q <= rd_word;
        end
    end

    assert_occ_bound_R8: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_W'(BUF_BITS));
endmodule

// File: rtl/fe_frame_ctrl.sv
module fe_frame_ctrl
    import fe_pack_pkg::*;
#(
    parameter int OCC_W  = 9,
    parameter int TAKE_W = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [OCC_W-1:0]   occ,
    output logic [TAKE_W-1:0]  take,
    output logic [FCODE_W-1:0] frame_hdr
);
    frame_kind_e kind_q, kind_n;

    always_comb begin
        if (occ == '0) begin
            kind_n = FR_IDLE;
            take   = '0;
        end else if (occ < OCC_W'(FRAME_W)) begin
            kind_n = FR_TAIL;
            take   = TAKE_W'(occ);
        end else begin
            kind_n = FR_FULL;
            take   = TAKE_W'(FRAME_W);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) kind_q <= FR_IDLE;
        else     kind_q <= kind_n;
    end

    always_comb begin
        unique case (kind_q)
            FR_IDLE: frame_hdr = CODE_IDLE;
            FR_TAIL: frame_hdr = CODE_TAIL;
            FR_FULL: frame_hdr = CODE_FULL;
            default: frame_hdr = CODE_IDLE;
        endcase
    end

    assert_full_needs_fill_R6: assert property (@(posedge clk) disable iff (rst)
        (kind_q == FR_FULL) |-> ($past(occ) >= OCC_W'(FRAME_W)));
    assert_tail_partial_R6: assert property (@(posedge clk) disable iff (rst)
        (kind_q == FR_TAIL) |-> ($past(occ) != '0 && $past(occ) < OCC_W'(FRAME_W)));
endmodule

// File: rtl/fe_derand_packer.sv
module fe_derand_packer
    import fe_pack_pkg::*;
#(
    parameter int NCH      = 16,
    parameter int BUF_BITS = 256,
    parameter int OCC_W    = $clog2(BUF_BITS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [BXID_W-1:0]     in_bxid,
    input  logic [NCH-1:0]        in_hit_mask,
    input  logic [NCH*WORD_W-1:0] in_ch_data,
    input  logic                  cmd_veto,
    input  logic                  cmd_nzs,
    output logic [FCODE_W-1:0]    frame_hdr,
    output logic [FRAME_W-1:0]    frame_data,
    output logic [OCC_W-1:0]      buf_occ,
    output logic                  ovf_flag,
    output logic [BXID_W-1:0]     ovf_bxid
);
    localparam int EV_MAX = EVHDR_W + WORD_W * NCH;
    localparam int LEN_W  = $clog2(EV_MAX + 1);
    localparam int TAKE_W = $clog2(FRAME_W + 1);

    logic [EV_MAX-1:0] ev_bits;
    logic [LEN_W-1:0]  ev_len;
    logic [TAKE_W-1:0] take;
    logic              offered, fits, accept;

    fe_event_builder #(.NCH(NCH), .EV_MAX(EV_MAX), .LEN_W(LEN_W)) u_build (
        .bxid(in_bxid), .hit_mask(in_hit_mask), .ch_data(in_ch_data),
        .nzs(cmd_nzs), .ev_bits(ev_bits), .ev_len(ev_len)
    );

    fe_frame_ctrl #(.OCC_W(OCC_W), .TAKE_W(TAKE_W)) u_ctrl (
        .clk(clk), .rst(rst), .occ(buf_occ), .take(take), .frame_hdr(frame_hdr)
    );

    assign offered = in_valid && !cmd_veto;
    assign fits    = (OCC_W + 1)'(ev_len) <= (OCC_W + 1)'(BUF_BITS) - (OCC_W + 1)'(buf_occ);
    assign accept  = offered && fits;

    fe_bit_fifo #(.BUF_BITS(BUF_BITS), .EV_MAX(EV_MAX), .LEN_W(LEN_W),
                  .OCC_W(OCC_W), .TAKE_W(TAKE_W)) u_fifo (
        .clk(clk), .rst(rst), .wr_en(accept), .wr_bits(ev_bits), .wr_len(ev_len),
        .rd_take(take), .occ(buf_occ), .frame_q(frame_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag <= 1'b0;
            ovf_bxid <= '0;
        end else if (offered && !fits) begin
            ovf_flag <= 1'b1;
            ovf_bxid <= in_bxid;
        end
    end

    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (frame_hdr == CODE_IDLE) |-> (frame_data == '0));
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);
    assert_veto_no_growth_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cmd_veto) |=> (buf_occ <= $past(buf_occ)));
    assert_veto_no_ovf_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cmd_veto && !ovf_flag) |=> !ovf_flag);
endmodule

// File: tb/fe_derand_packer_tb.sv
module fe_derand_packer_tb;
    localparam int NCH = 16;
    localparam int BUF = 256;
    localparam int OW  = $clog2(BUF + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [11:0] in_bxid = '0;
    logic [NCH-1:0] in_hit_mask = '0;
    logic [NCH*5-1:0] in_ch_data = '0;
    logic cmd_veto = 1'b0, cmd_nzs = 1'b0;
    logic [3:0] frame_hdr;
    logic [79:0] frame_data;
    logic [OW-1:0] buf_occ;
    logic ovf_flag;
    logic [11:0] ovf_bxid;

    int checks = 0, errors = 0;
    bit mq[$];
    logic [79:0] e_frame = '0;
    logic [3:0]  e_hdr = 4'h0;
    bit          e_ovf = 0;
    logic [11:0] e_lost = '0;
    string ph = "R9";

    always #2 clk = ~clk;

    fe_derand_packer #(.NCH(NCH), .BUF_BITS(BUF)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bxid(in_bxid),
        .in_hit_mask(in_hit_mask), .in_ch_data(in_ch_data), .cmd_veto(cmd_veto),
        .cmd_nzs(cmd_nzs), .frame_hdr(frame_hdr), .frame_data(frame_data),
        .buf_occ(buf_occ), .ovf_flag(ovf_flag), .ovf_bxid(ovf_bxid)
    );

    task automatic chk(input bit ok, input string rq, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s/%s actual=%h expected=%h", rq, ph, act, exp);
        end
    endtask

    task automatic model_step();
        int take, freeb, len, n;
        take = (mq.size() >= 80) ? 80 : mq.size();
        freeb = BUF - mq.size();
        e_hdr = (take == 0) ? 4'h0 : (take == 80 ? 4'h6 : 4'h9);
        e_frame = '0;
        for (int j = 0; j < take; j++) e_frame[79-j] = mq.pop_front();
        if (in_valid && !cmd_veto) begin
            n = 0;
            for (int c = 0; c < NCH; c++) if (cmd_nzs || in_hit_mask[c]) n++;
            len = 24 + 5 * n;
            if (len <= freeb) begin
                for (int b = 11; b >= 0; b--) mq.push_back(in_bxid[b]);
                for (int b = 7; b >= 0; b--) mq.push_back(n[b]);
                for (int b = 3; b >= 0; b--) mq.push_back(b == 3 ? cmd_nzs : 1'b0);
                for (int c = 0; c < NCH; c++)
                    if (cmd_nzs || in_hit_mask[c])
                        for (int b = 4; b >= 0; b--) mq.push_back(in_ch_data[c*5+b]);
            end else begin
                e_ovf = 1;
                e_lost = in_bxid;
            end
        end
    endtask

    task automatic compare();
        chk(frame_data == e_frame, "R4", frame_data, e_frame);
        chk(frame_hdr == e_hdr, "R6", 80'(frame_hdr), 80'(e_hdr));
        chk(buf_occ == OW'(mq.size()), "R7", 80'(buf_occ), 80'(mq.size()));
        chk(ovf_flag == e_ovf, "R8", 80'(ovf_flag), 80'(e_ovf));
        chk(ovf_bxid == e_lost, "R8", 80'(ovf_bxid), 80'(e_lost));
    endtask

    task automatic cyc(input bit v, input logic [11:0] bx, input logic [NCH-1:0] m,
                       input bit veto, input bit nzs);
        @(negedge clk);
        in_valid = v; in_bxid = bx; in_hit_mask = m; cmd_veto = veto; cmd_nzs = nzs;
        for (int c = 0; c < NCH; c++) in_ch_data[c*5 +: 5] = 5'(bx * 7 + c * 13 + 3);
        model_step();
        @(posedge clk); #1;
        compare();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        ph = "R9";
        compare();
        @(negedge clk); rst = 1'b0;

        ph = "R1_R2_empty";
        cyc(1, 12'h123, 16'h0000, 0, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);

        ph = "R2_sparse";
        cyc(1, 12'h0A5, 16'h0005, 0, 0);
        cyc(1, 12'h0A6, 16'h8001, 0, 0);
        cyc(1, 12'h0A7, 16'h0F0F, 0, 0);
        cyc(1, 12'hFFF, 16'hFFFF, 0, 0);
        repeat (4) cyc(0, 0, 0, 0, 0);

        ph = "R3_nzs";
        cyc(1, 12'h321, 16'h0000, 0, 1);
        cyc(1, 12'h322, 16'h0010, 0, 1);
        repeat (4) cyc(0, 0, 0, 0, 0);

        ph = "R5_veto";
        cyc(1, 12'h555, 16'hFFFF, 1, 0);
        cyc(1, 12'h556, 16'h0003, 1, 1);
        cyc(1, 12'h557, 16'h0001, 0, 0);
        repeat (3) cyc(0, 0, 0, 0, 0);

        ph = "R4_stream";
        for (int k = 0; k < 20; k++) cyc(1, 12'(12'h200 + k), 16'(k * 16'h1357), 0, 0);
        repeat (6) cyc(0, 0, 0, 0, 0);

        ph = "R8_overflow";
        for (int k = 0; k < 18; k++) cyc(1, 12'(12'h700 + k), 16'h0000, 0, 1);
        cyc(1, 12'h7F0, 16'h0000, 1, 1);
        cyc(1, 12'h7F1, 16'h0001, 0, 0);
        repeat (6) cyc(0, 0, 0, 0, 0);

        ph = "R9_reset";
        @(negedge clk); rst = 1'b1; in_valid = 0;
        mq.delete(); e_frame = '0; e_hdr = 4'h0; e_ovf = 0; e_lost = '0;
        @(posedge clk); #1;
        compare();
        @(negedge clk); rst = 1'b0;
        cyc(1, 12'h0AB, 16'h0002, 0, 0);
        cyc(0, 0, 0, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule